// File: doc/BRIEF.md
# Partitioned Per-Packet IV Generator

This block hands out one 64-bit initialisation value per packet for a counter-mode encryption engine. Each value must stay unique under the current key. The IV is split into two fields. The upper field carries a small identifier for the engine, and that identifier is loaded at SA setup. The lower field comes from a local sequence source. Several engines that serve the same security association therefore produce disjoint sets of IVs. Each engine keeps only its own state and never has to agree with the others on per-packet values.

Two sequence sources are available, and the choice is made when the SA is reset. The first is a plain binary counter that starts at zero. The second is a maximal-length Galois LFSR that starts at a nonzero seed. Its next-state logic is a shift plus a few XORs, so it has no carry chain. The field split is a build-time choice. Setting the identifier width to zero gives a single engine that uses the whole IV as sequence.

A packet path raises a request and receives a grant with the IV one cycle later. Once every value of the sequence field has been issued, the block raises an exhausted flag. It then refuses further requests until the next SA reset.

Top module: `iv_partition_gen`

## Requirements
- R1: After rst_n is released, gnt_o and exhausted_o are 0, the source is the counter, and the identifier is 0. A first request therefore returns an all-zero IV.
- R2: A request made while no SA reset is applied and exhausted_o is 0 produces gnt_o = 1 in the following cycle. gnt_o is never 1 without such a request. iv_o holds its value in any cycle without a grant.
- R3: In every granted IV, bits [IV_W-1 : IV_W-ID_W] equal the engine identifier captured at the most recent SA reset, and the low IV_W-ID_W bits are the sequence value.
- R4: In counter mode (cfg_mode_i = 0 at SA reset), the first grant after an SA reset carries sequence 0, and each later grant carries the previous value plus 1.
- R5: In LFSR mode (cfg_mode_i = 1 at SA reset), the first grant carries SEED. Each later value is the previous one shifted right by one bit, XORed with the tap mask when the bit shifted out was 1. For a 12-bit sequence the mask is 0x829. A zero sequence value is never produced.
- R6: exhausted_o rises at the same edge as the grant whose successor value would equal the start value. In counter mode this is after 2^W grants, and in LFSR mode after 2^W - 1 grants, where W is the sequence width. Every sequence value issued in that span is distinct.
- R7: While exhausted_o is 1, requests are not granted and iv_o does not change.
- R8: An SA reset (sa_rst_i = 1) reloads the start value of the selected mode and clears exhausted_o. It also captures cfg_mode_i and cfg_engine_id_i. A request in that same cycle is not granted.
- R9: Changes to cfg_mode_i or cfg_engine_id_i between SA resets have no effect on the IVs issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sa_rst_i | input | 1 | Start a new SA: reload sequence, capture configuration |
| cfg_mode_i | input | 1 | Sequence source: 0 counter, 1 LFSR (captured at SA reset) |
| cfg_engine_id_i | input | max(ID_W,1) | Engine identifier (captured at SA reset) |
| req_i | input | 1 | Request one IV |
| gnt_o | output | 1 | Request granted; iv_o is valid in this cycle |
| iv_o | output | IV_W | Issued IV: identifier field above sequence field |
| exhausted_o | output | 1 | Sequence used up; no further grants |

## Verification
A corrupted sequence register shows up on iv_o at the very next grant, as a value that differs from the counter or LFSR step predicted from the previous one. A corrupted identifier register shows up in the upper field of that same grant. A wrong exhaustion decision is visible only at the boundary. It appears either as a flag raised before the full 2^W or 2^W - 1 span has been issued, or as a repeated value or an extra grant just after that span. For this reason both modes are driven through complete periods at a reduced sequence width.

// File: rtl/iv_gen_pkg.sv
package iv_gen_pkg;

    typedef enum logic {
        IV_MODE_COUNT = 1'b0,
        IV_MODE_LFSR  = 1'b1
    } iv_mode_e;

    function automatic logic [63:0] tap_bit(input int unsigned t);
        return 64'd1 << (t - 1);
    endfunction

    // Galois feedback mask for a maximal-length sequence of the given width.
    // Widths outside this set fall back to a two-tap mask whose period is not guaranteed.
    function automatic logic [63:0] lfsr_tap_mask(input int unsigned width);
        logic [63:0] m;
        case (width)
            4:       m = tap_bit(4)  | tap_bit(3);
            8:       m = tap_bit(8)  | tap_bit(6)  | tap_bit(5)  | tap_bit(4);
            12:      m = tap_bit(12) | tap_bit(6)  | tap_bit(4)  | tap_bit(1);
            16:      m = tap_bit(16) | tap_bit(15) | tap_bit(13) | tap_bit(4);
            20:      m = tap_bit(20) | tap_bit(17);
            24:      m = tap_bit(24) | tap_bit(23) | tap_bit(22) | tap_bit(17);
            28:      m = tap_bit(28) | tap_bit(25);
            32:      m = tap_bit(32) | tap_bit(22) | tap_bit(2)  | tap_bit(1);
            40:      m = tap_bit(40) | tap_bit(38) | tap_bit(21) | tap_bit(19);
            48:      m = tap_bit(48) | tap_bit(47) | tap_bit(21) | tap_bit(20);
            56:      m = tap_bit(56) | tap_bit(55) | tap_bit(35) | tap_bit(34);
            60:      m = tap_bit(60) | tap_bit(59);
            63:      m = tap_bit(63) | tap_bit(62);
            64:      m = tap_bit(64) | tap_bit(63) | tap_bit(61) | tap_bit(60);
            default: m = tap_bit(width) | tap_bit(width - 1);
        endcase
        return m;
    endfunction

endpackage

// File: rtl/iv_seq_next.sv
module iv_seq_next
    import iv_gen_pkg::*;
#(
    parameter int unsigned SEQ_W = 56,
    parameter logic [63:0] SEED  = 64'd1
) (
    input  logic [SEQ_W-1:0] seq_i,
    input  iv_mode_e         mode_i,
    output logic [SEQ_W-1:0] next_o,
    output logic [SEQ_W-1:0] start_o
);

    localparam logic [63:0]      MASK_FULL = lfsr_tap_mask(SEQ_W);
    localparam logic [SEQ_W-1:0] MASK      = MASK_FULL[SEQ_W-1:0];
    localparam logic [SEQ_W-1:0] SEED_S    = SEED[SEQ_W-1:0];

    logic [SEQ_W-1:0] cnt_next;
    logic [SEQ_W-1:0] lfsr_next;

    always_comb begin
        cnt_next  = seq_i + SEQ_W'(1);
        lfsr_next = (seq_i >> 1) ^ (seq_i[0] ? MASK : '0);
        // the LFSR is never loaded with zero; recover to the seed if it ever is
        if (seq_i == '0) begin
            lfsr_next = SEED_S;
        end
        if (mode_i == IV_MODE_LFSR) begin
            next_o  = lfsr_next;
            start_o = SEED_S;
        end else begin
            next_o  = cnt_next;
            start_o = '0;
        end
    end

endmodule

// File: rtl/iv_field_pack.sv
module iv_field_pack #(
    parameter int unsigned IV_W = 64,
    parameter int unsigned ID_W = 8,
    localparam int unsigned SEQ_W = IV_W - ID_W,
    localparam int unsigned IDP   = (ID_W > 0) ? ID_W : 1
) (
    input  logic [IDP-1:0]   id_i,
    input  logic [SEQ_W-1:0] seq_i,
    output logic [IV_W-1:0]  iv_o
);

    generate
        if (ID_W == 0) begin : g_single_engine
            logic unused_id;
            assign unused_id = ^id_i;
            assign iv_o      = seq_i;
        end else begin : g_partitioned
            assign iv_o = {id_i, seq_i};
        end
    endgenerate

endmodule

// File: rtl/iv_partition_gen.sv
module iv_partition_gen
    import iv_gen_pkg::*;
#(
    parameter int unsigned IV_W = 64,
    parameter int unsigned ID_W = 8,
    parameter logic [63:0] SEED = 64'd1,
    localparam int unsigned SEQ_W = IV_W - ID_W,
    localparam int unsigned IDP   = (ID_W > 0) ? ID_W : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sa_rst_i,
    input  logic             cfg_mode_i,
    input  logic [IDP-1:0]   cfg_engine_id_i,
    input  logic             req_i,
    output logic             gnt_o,
    output logic [IV_W-1:0]  iv_o,
    output logic             exhausted_o
);

    localparam logic [SEQ_W-1:0] SEED_S = SEED[SEQ_W-1:0];

    typedef struct packed {
        logic [SEQ_W-1:0] seq;
        logic [IDP-1:0]   id;
        iv_mode_e         mode;
        logic             exh;
        logic             gnt;
        logic [IV_W-1:0]  iv;
    } gen_st_t;

    gen_st_t st_q, st_d;

    logic [SEQ_W-1:0] seq_next;
    logic [SEQ_W-1:0] seq_start;
    logic [IV_W-1:0]  iv_now;
    iv_mode_e         cfg_mode;

    assign cfg_mode = iv_mode_e'(cfg_mode_i);

    iv_seq_next #(
        .SEQ_W (SEQ_W),
        .SEED  (SEED)
    ) u_seq (
        .seq_i   (st_q.seq),
        .mode_i  (st_q.mode),
        .next_o  (seq_next),
        .start_o (seq_start)
    );

    iv_field_pack #(
        .IV_W (IV_W),
        .ID_W (ID_W)
    ) u_pack (
        .id_i  (st_q.id),
        .seq_i (st_q.seq),
        .iv_o  (iv_now)
    );

    always_comb begin
        st_d     = st_q;
        st_d.gnt = 1'b0;
        if (sa_rst_i) begin
            st_d.mode = cfg_mode;
            st_d.id   = cfg_engine_id_i;
            st_d.seq  = (cfg_mode == IV_MODE_LFSR) ? SEED_S : '0;
            st_d.exh  = 1'b0;
        end else if (req_i && !st_q.exh) begin
            st_d.gnt = 1'b1;
            st_d.iv  = iv_now;
            st_d.seq = seq_next;
            st_d.exh = (seq_next == seq_start);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= gen_st_t'('0);
        end else begin
            st_q <= st_d;
        end
    end

    assign gnt_o       = st_q.gnt;
    assign iv_o        = st_q.iv;
    assign exhausted_o = st_q.exh;

    // R2: a grant always answers a serviceable request of the previous cycle
    assert_grant_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_o |-> ($past(req_i) && !$past(sa_rst_i) && !$past(exhausted_o)));

    // R5: the LFSR state is never zero
    assert_lfsr_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == IV_MODE_LFSR) |-> (st_q.seq != '0));

    // R6: exhaustion only appears together with the grant that used the last value
    assert_exh_with_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(exhausted_o) |-> gnt_o);

    // R7: an exhausted generator grants nothing and holds its output
    assert_exh_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (exhausted_o && !sa_rst_i) |=> (!gnt_o && $stable(iv_o)));

    // R8: SA reset clears exhaustion and suppresses a same-cycle grant
    assert_sa_rst_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sa_rst_i |=> (!exhausted_o && !gnt_o));

endmodule

// File: tb/sim_iv_partition_gen.sv
module sim_iv_partition_gen;

    localparam int unsigned IV_W  = 16;
    localparam int unsigned ID_W  = 4;
    localparam int unsigned SEQ_W = IV_W - ID_W;
    localparam logic [SEQ_W-1:0] SEED_V = 12'h5A3;
    localparam logic [SEQ_W-1:0] MASK_V = 12'h829;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sa_rst_i = 1'b0;
    logic             cfg_mode_i = 1'b0;
    logic [ID_W-1:0]  cfg_engine_id_i = '0;
    logic             req_i = 1'b0;
    logic             gnt_o;
    logic [IV_W-1:0]  iv_o;
    logic             exhausted_o;

    int tests_run = 0;
    int tests_failed = 0;
    bit seen [0:4095];

    always #5 clk = ~clk;

    iv_partition_gen #(
        .IV_W (IV_W),
        .ID_W (ID_W),
        .SEED (64'(SEED_V))
    ) u0 (
        .clk             (clk),
        .rst_n           (rst_n),
        .sa_rst_i        (sa_rst_i),
        .cfg_mode_i      (cfg_mode_i),
        .cfg_engine_id_i (cfg_engine_id_i),
        .req_i           (req_i),
        .gnt_o           (gnt_o),
        .iv_o            (iv_o),
        .exhausted_o     (exhausted_o)
    );

    function automatic logic [SEQ_W-1:0] lfsr_step(input logic [SEQ_W-1:0] s);
        return (s >> 1) ^ (s[0] ? MASK_V : '0);
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint unsigned act, input longint unsigned exp);
        tests_run++;
        if (!ok) begin
            tests_failed++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
        end
    endtask

    task automatic tick(input logic r);
        req_i = r;
        @(negedge clk);
    endtask

    task automatic sa_reset(input logic mode, input logic [ID_W-1:0] id);
        sa_rst_i        = 1'b1;
        cfg_mode_i      = mode;
        cfg_engine_id_i = id;
        req_i           = 1'b0;
        @(negedge clk);
        sa_rst_i = 1'b0;
    endtask

    task automatic t_reset();
        chk(gnt_o == 1'b0, "R1", "gnt after reset", gnt_o, 0);
        chk(exhausted_o == 1'b0, "R1", "exhausted after reset", exhausted_o, 0);
        tick(1'b1);
        chk(gnt_o == 1'b1, "R1", "first grant", gnt_o, 1);
        chk(iv_o == '0, "R1", "first iv after reset", iv_o, 0);
        tick(1'b0);
    endtask

    task automatic t_counter_basic();
        sa_reset(1'b0, 4'hA);
        for (int i = 0; i < 8; i++) begin
            tick(1'b1);
            chk(gnt_o == 1'b1, "R2", "grant on request", gnt_o, 1);
            chk(iv_o == {4'hA, 12'(i)}, "R4", "counter iv (R3 id field)", iv_o, {4'hA, 12'(i)});
        end
    endtask

    task automatic t_req_gaps();
        logic [IV_W-1:0] held;
        held = iv_o;
        tick(1'b0);
        chk(gnt_o == 1'b0, "R2", "no grant without request", gnt_o, 0);
        chk(iv_o == held, "R2", "iv held without grant", iv_o, held);
        tick(1'b0);
        tick(1'b1);
        chk(iv_o == {4'hA, 12'd8}, "R4", "counter resumes after gap", iv_o, {4'hA, 12'd8});
    endtask

    task automatic t_cfg_ignored();
        cfg_mode_i      = 1'b1;
        cfg_engine_id_i = 4'h3;
        tick(1'b1);
        chk(iv_o == {4'hA, 12'd9}, "R9", "config change without SA reset", iv_o, {4'hA, 12'd9});
        tick(1'b1);
        chk(iv_o == {4'hA, 12'd10}, "R9", "mode still counter", iv_o, {4'hA, 12'd10});
    endtask

    task automatic t_sa_rst_with_req();
        sa_rst_i        = 1'b1;
        cfg_mode_i      = 1'b0;
        cfg_engine_id_i = 4'h2;
        req_i           = 1'b1;
        @(negedge clk);
        sa_rst_i = 1'b0;
        chk(gnt_o == 1'b0, "R8", "no grant during SA reset", gnt_o, 0);
        tick(1'b1);
        chk(iv_o == {4'h2, 12'd0}, "R8", "restart from zero with new id", iv_o, {4'h2, 12'd0});
        tick(1'b0);
    endtask

    task automatic t_lfsr_basic();
        logic [SEQ_W-1:0] s;
        sa_reset(1'b1, 4'h6);
        s = SEED_V;
        for (int i = 0; i < 20; i++) begin
            tick(1'b1);
            chk(gnt_o == 1'b1 && iv_o == {4'h6, s}, "R5", "lfsr iv", iv_o, {4'h6, s});
            s = lfsr_step(s);
        end
        tick(1'b0);
    endtask

    task automatic t_counter_exhaust();
        int errs;
        int early;
        logic [IV_W-1:0] held;
        errs  = 0;
        early = 0;
        sa_reset(1'b0, 4'h1);
        for (int i = 0; i < 4096; i++) seen[i] = 1'b0;
        for (int i = 0; i < 4096; i++) begin
            tick(1'b1);
            if (!gnt_o || iv_o != {4'h1, 12'(i)} || seen[iv_o[11:0]]) errs++;
            seen[iv_o[11:0]] = 1'b1;
            if (i < 4095 && exhausted_o) early++;
        end
        chk(errs == 0, "R4", "counter full period mismatches", errs, 0);
        chk(early == 0, "R6", "counter exhausted too early", early, 0);
        chk(exhausted_o == 1'b1, "R6", "counter exhausted after 4096", exhausted_o, 1);
        held = iv_o;
        for (int i = 0; i < 3; i++) begin
            tick(1'b1);
            chk(gnt_o == 1'b0, "R7", "no grant when exhausted", gnt_o, 0);
            chk(iv_o == held, "R7", "iv held when exhausted", iv_o, held);
        end
        sa_reset(1'b1, 4'h1);
        chk(exhausted_o == 1'b0, "R8", "SA reset clears exhausted", exhausted_o, 0);
        tick(1'b1);
        chk(iv_o == {4'h1, SEED_V}, "R8", "reload seed after exhaustion", iv_o, {4'h1, SEED_V});
        tick(1'b0);
    endtask

    task automatic t_lfsr_exhaust();
        int errs;
        int early;
        logic [SEQ_W-1:0] s;
        errs  = 0;
        early = 0;
        sa_reset(1'b1, 4'h7);
        s = SEED_V;
        for (int i = 0; i < 4096; i++) seen[i] = 1'b0;
        for (int i = 0; i < 4095; i++) begin
            tick(1'b1);
            if (!gnt_o || iv_o != {4'h7, s} || iv_o[11:0] == '0 || seen[iv_o[11:0]]) errs++;
            seen[iv_o[11:0]] = 1'b1;
            if (i < 4094 && exhausted_o) early++;
            s = lfsr_step(s);
        end
        chk(errs == 0, "R5", "lfsr full period mismatches", errs, 0);
        chk(early == 0, "R6", "lfsr exhausted too early", early, 0);
        chk(exhausted_o == 1'b1, "R6", "lfsr exhausted after 4095", exhausted_o, 1);
        tick(1'b1);
        chk(gnt_o == 1'b0, "R7", "lfsr no grant when exhausted", gnt_o, 0);
        tick(1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests_run++;
        tests_failed++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_counter_basic();
        t_req_gaps();
        t_cfg_ignored();
        t_sa_rst_with_req();
        t_lfsr_basic();
        t_counter_exhaust();
        t_lfsr_exhaust();
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule